// File: doc/BRIEF.md
# Physical Address Router with Byte Fan-Out

This block sits between a core's load/store stage and the rest of the system. It takes one physical access at a time (byte, halfword, word or doubleword, read or write) and routes it to main memory, to a small read-only configuration ROM, or to one of four peripheral windows: timer, interrupt controller, serial port and block storage. Main memory sees the address with its base already subtracted. A multi-byte access that lies wholly in main memory, and does not wrap the address space, goes out as one memory transaction. Any other access is split into byte transactions, lowest address first, and each byte is routed on its own.

A separate combinational query port reports whether an address is backed by anything. It is used for probing before an access is issued. In 32-bit mode both the access path and the query cut the address to its low 32 bits before decoding. An access to an address with no target does not stall. It completes with an error flag, its write bytes are dropped, and its read bytes return zero.

Requests and responses use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from then until the response has been taken. The response holds `rsp_rdata` and `rsp_err` stable while `rsp_valid` is high and `rsp_ready` is low. Each downstream transaction on the memory or device port holds its address and data until that port's ready input is seen high.

Top module: `addr_router`

## Requirements
- R1: A request is accepted only while `req_ready` is high. `req_ready` stays low until the response has been taken. `rsp_valid`, `rsp_rdata` and `rsp_err` hold steady while `rsp_ready` is low.
- R2: An access whose masked address is at or above `DRAM_BASE`, and for which address + width - 1 does not wrap, goes out as exactly one memory transaction. Its `mem_offset` is the address minus `DRAM_BASE`, and its `mem_size` is the request size code (0=1 byte, 1=2, 2=4, 3=8). Data is right-aligned at bit 0, and read data above the access width is zero.
- R3: Every other multi-byte access is issued as width byte transactions at ascending addresses. Byte k of the data is carried on bits [8k+7:8k] (little-endian). Each byte is routed by its own address, and memory bytes use `mem_size`=0.
- R4: The device windows and their `dev_sel` codes are: timer 0x0200_0000–0x0200_FFFF = 0; interrupt controller 0x0C00_0000–0x0FFF_FFFF = 1; serial 0x1000_0000–0x1000_00FF = 2; storage 0x1000_1000–0x1000_1FFF = 3. `dev_addr` carries the full byte address.
- R5: Reads in 0x1020–0x1FFF return the ROM byte at index address - 0x1020. A write there is an error and causes no downstream transaction.
- R6: A byte with no target sets `rsp_err`, returns zero in its lane and issues no transaction. The other bytes of the access are still carried out.
- R7: When `mode32` is high, the access and query addresses are cut to their low 32 bits. A span that runs past 0xFFFF_FFFF wraps to 0 and therefore uses byte fan-out.
- R8: `qry_ok` is high for every ROM and device window address, and for memory addresses whose offset is below `MEM_BYTES`. It is low for everything else.
- R9: A write response returns `rsp_rdata` = 0.
- R10: Downstream `mem_valid`/`dev_valid` stay high with a stable address until their ready input is seen high, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode32 | input | 1 | Cut addresses to 32 bits |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write |
| req_size | input | 2 | Size code, width = 1 << code bytes |
| req_addr | input | ADDR_W | Physical address |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 64 | Read data, right-aligned |
| rsp_err | output | 1 | Some byte had no target |
| mem_valid | output | 1 | Memory transaction valid |
| mem_ready | input | 1 | Memory accepts/returns this cycle |
| mem_write | output | 1 | Memory write |
| mem_size | output | 2 | Memory size code |
| mem_offset | output | ADDR_W | Address minus DRAM_BASE |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid with mem_ready |
| dev_valid | output | 1 | Device byte transaction valid |
| dev_ready | input | 1 | Device accepts/returns this cycle |
| dev_write | output | 1 | Device write |
| dev_sel | output | 2 | Device select code |
| dev_addr | output | 32 | Device byte address |
| dev_wdata | output | 8 | Device write byte |
| dev_rdata | input | 8 | Device read byte, valid with dev_ready |
| rom_idx | output | 12 | ROM byte index |
| rom_rdata | input | 8 | ROM byte, combinational |
| qry_addr | input | ADDR_W | Validity query address |
| qry_ok | output | 1 | Query address is backed |

## Verification
The bench builds the router with a 64-bit address and `MEM_BYTES` = 256. At that size the memory-capacity edge of the validity query sits at 0x8000_0100, and a 256-byte memory model can cover every offset the bench uses. With this setup the bench sweeps every size over memory offsets, all four device windows and the ROM window. It also drives the corner spans that cross into memory from unmapped space, wrap the 64-bit and 32-bit address spaces, and hit the edges of each window. Memory and device ready inputs stall on a fixed rotating pattern, so every transaction has to survive back-pressure.

// File: rtl/ar_pkg.sv
package ar_pkg;
  typedef enum logic [2:0] {
    RG_NONE, RG_DRAM, RG_ROM, RG_TIMER, RG_INTC, RG_UART, RG_DISK
  } region_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_RESP} state_e;

  localparam logic [31:0] ROM_LO  = 32'h0000_1020;
  localparam logic [31:0] ROM_HI  = 32'h0000_1FFF;
  localparam logic [31:0] TMR_LO  = 32'h0200_0000;
  localparam logic [31:0] TMR_HI  = 32'h0200_FFFF;
  localparam logic [31:0] INTC_LO = 32'h0C00_0000;
  localparam logic [31:0] INTC_HI = 32'h0FFF_FFFF;
  localparam logic [31:0] UART_LO = 32'h1000_0000;
  localparam logic [31:0] UART_HI = 32'h1000_00FF;
  localparam logic [31:0] DISK_LO = 32'h1000_1000;
  localparam logic [31:0] DISK_HI = 32'h1000_1FFF;
endpackage

// File: rtl/ar_decode.sv
module ar_decode
  import ar_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter logic [ADDR_W-1:0] DRAM_BASE = 'h8000_0000,
  parameter logic [ADDR_W-1:0] MEM_BYTES = 'h0800_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [ADDR_W-1:0] dram_off,
  output logic [11:0]       rom_idx,
  output logic              in_cap
);
  logic        hi_zero;
  logic [31:0] lo;

  assign lo       = addr[31:0];
  assign hi_zero  = (addr[ADDR_W-1:32] == '0);
  assign dram_off = addr - DRAM_BASE;
  assign in_cap   = (dram_off < MEM_BYTES);
  assign rom_idx  = lo[11:0] - 12'h020;

  always_comb begin
    region = RG_NONE;
    if (addr >= DRAM_BASE)                               region = RG_DRAM;
    else if (hi_zero && lo >= ROM_LO  && lo <= ROM_HI)   region = RG_ROM;
    else if (hi_zero && lo >= TMR_LO  && lo <= TMR_HI)   region = RG_TIMER;
    else if (hi_zero && lo >= INTC_LO && lo <= INTC_HI)  region = RG_INTC;
    else if (hi_zero && lo >= UART_LO && lo <= UART_HI)  region = RG_UART;
    else if (hi_zero && lo >= DISK_LO && lo <= DISK_HI)  region = RG_DISK;
  end
endmodule

// File: rtl/ar_seq.sv
module ar_seq
  import ar_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter logic [ADDR_W-1:0] DRAM_BASE = 'h8000_0000,
  parameter logic [ADDR_W-1:0] MEM_BYTES = 'h0800_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode32,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_offset,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  output logic              dev_valid,
  input  logic              dev_ready,
  output logic              dev_write,
  output logic [1:0]        dev_sel,
  output logic [31:0]       dev_addr,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata,
  output logic [11:0]       rom_idx,
  input  logic [7:0]        rom_rdata
);
  localparam int SUM_W = ADDR_W + 1;

  state_e            state;
  logic              q_write, q_fast, q_m32, err;
  logic [1:0]        q_size;
  logic [ADDR_W-1:0] q_addr;
  logic [63:0]       q_wdata, acc;
  logic [2:0]        idx, last_idx;

  // Head decode: classifies the incoming request for the single-transaction path.
  logic [ADDR_W-1:0] h_addr, h_off;
  logic [SUM_W-1:0]  h_sum;
  logic [11:0]       h_rom;
  logic              h_cap, h_wrap;
  region_e           h_region;
  logic [2:0]        h_last;

  assign h_addr = mode32 ? {{(ADDR_W-32){1'b0}}, req_addr[31:0]} : req_addr;
  assign h_last = 3'((4'd1 << req_size) - 4'd1);
  assign h_sum  = {1'b0, h_addr} + SUM_W'(h_last);
  assign h_wrap = mode32 ? h_sum[32] : h_sum[ADDR_W];

  ar_decode #(.ADDR_W(ADDR_W), .DRAM_BASE(DRAM_BASE), .MEM_BYTES(MEM_BYTES)) u_head_dec (
    .addr(h_addr), .region(h_region), .dram_off(h_off), .rom_idx(h_rom), .in_cap(h_cap)
  );

  // Byte decode: routes each byte of a fanned-out access by its own address.
  logic [ADDR_W-1:0] b_sum, b_addr, b_off;
  logic [11:0]       b_rom;
  logic              b_cap;
  region_e           b_region;

  assign b_sum  = q_addr + ADDR_W'(idx);
  assign b_addr = q_m32 ? {{(ADDR_W-32){1'b0}}, b_sum[31:0]} : b_sum;

  ar_decode #(.ADDR_W(ADDR_W), .DRAM_BASE(DRAM_BASE), .MEM_BYTES(MEM_BYTES)) u_byte_dec (
    .addr(b_addr), .region(b_region), .dram_off(b_off), .rom_idx(b_rom), .in_cap(b_cap)
  );

  assign last_idx = 3'((4'd1 << q_size) - 4'd1);

  // Step datapath
  logic        step_done, step_err;
  logic [7:0]  step_byte;
  logic [63:0] fast_data, fast_mask;
  logic [7:0]  wr_byte;

  assign wr_byte   = q_wdata[{idx, 3'b000} +: 8];
  assign fast_mask = (q_size == 2'd3) ? '1 : ((64'd1 << (7'd8 << q_size)) - 64'd1);
  assign fast_data = mem_rdata & fast_mask;

  always_comb begin
    mem_valid  = 1'b0;
    mem_write  = q_write;
    mem_size   = 2'd0;
    mem_offset = b_off;
    mem_wdata  = {56'd0, wr_byte};
    dev_valid  = 1'b0;
    dev_write  = q_write;
    dev_sel    = 2'd0;
    dev_addr   = b_addr[31:0];
    dev_wdata  = wr_byte;
    rom_idx    = b_rom;
    step_done  = 1'b0;
    step_err   = 1'b0;
    step_byte  = 8'd0;
    if (state == ST_RUN) begin
      if (q_fast) begin
        mem_valid = 1'b1;
        mem_size  = q_size;
        mem_wdata = q_wdata;
        step_done = mem_ready;
      end else begin
        unique case (b_region)
          RG_DRAM: begin
            mem_valid = 1'b1;
            step_done = mem_ready;
            step_byte = mem_rdata[7:0];
          end
          RG_ROM: begin
            step_done = 1'b1;
            step_err  = q_write;
            step_byte = q_write ? 8'd0 : rom_rdata;
          end
          RG_TIMER, RG_INTC, RG_UART, RG_DISK: begin
            dev_valid = 1'b1;
            unique case (b_region)
              RG_TIMER: dev_sel = 2'd0;
              RG_INTC:  dev_sel = 2'd1;
              RG_UART:  dev_sel = 2'd2;
              default:  dev_sel = 2'd3;
            endcase
            step_done = dev_ready;
            step_byte = dev_rdata;
          end
          default: begin
            step_done = 1'b1;
            step_err  = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      q_write <= 1'b0;
      q_fast  <= 1'b0;
      q_m32   <= 1'b0;
      q_size  <= 2'd0;
      q_addr  <= '0;
      q_wdata <= '0;
      acc     <= '0;
      err     <= 1'b0;
      idx     <= 3'd0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          state   <= ST_RUN;
          q_write <= req_write;
          q_size  <= req_size;
          q_addr  <= h_addr;
          q_m32   <= mode32;
          q_wdata <= req_wdata;
          q_fast  <= (h_region == RG_DRAM) && !h_wrap;
          acc     <= '0;
          err     <= 1'b0;
          idx     <= 3'd0;
        end
        ST_RUN: if (step_done) begin
          if (q_fast) begin
            if (!q_write) acc <= fast_data;
            state <= ST_RESP;
          end else begin
            if (!q_write) acc[{idx, 3'b000} +: 8] <= step_byte;
            err <= err | step_err;
            if (idx == last_idx) state <= ST_RESP;
            else                 idx   <= idx + 3'd1;
          end
        end
        default: if (rsp_ready) state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_rdata = acc;
  assign rsp_err   = err;

  p_rsp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));
  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || dev_valid || rsp_valid) |-> !req_ready);
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_offset) && $stable(mem_size));
  p_dev_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid && !dev_ready |=> dev_valid && $stable(dev_addr) && $stable(dev_sel));
  p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && dev_valid));
  p_wr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && q_write |-> rsp_rdata == 64'd0);
endmodule

// File: rtl/addr_router.sv
module addr_router
  import ar_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter logic [ADDR_W-1:0] DRAM_BASE = 'h8000_0000,
  parameter logic [ADDR_W-1:0] MEM_BYTES = 'h0800_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode32,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_offset,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  output logic              dev_valid,
  input  logic              dev_ready,
  output logic              dev_write,
  output logic [1:0]        dev_sel,
  output logic [31:0]       dev_addr,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata,
  output logic [11:0]       rom_idx,
  input  logic [7:0]        rom_rdata,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_ok
);
  ar_seq #(.ADDR_W(ADDR_W), .DRAM_BASE(DRAM_BASE), .MEM_BYTES(MEM_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode32(mode32),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_size(mem_size), .mem_offset(mem_offset), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_write(dev_write), .dev_sel(dev_sel),
    .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .rom_idx(rom_idx), .rom_rdata(rom_rdata)
  );

  // Validity query (R8, R7): combinational, uses the live mode32.
  logic [ADDR_W-1:0] q_masked, q_off;
  logic [11:0]       q_rom;
  logic              q_cap;
  region_e           q_region;

  assign q_masked = mode32 ? {{(ADDR_W-32){1'b0}}, qry_addr[31:0]} : qry_addr;

  ar_decode #(.ADDR_W(ADDR_W), .DRAM_BASE(DRAM_BASE), .MEM_BYTES(MEM_BYTES)) u_qry_dec (
    .addr(q_masked), .region(q_region), .dram_off(q_off), .rom_idx(q_rom), .in_cap(q_cap)
  );

  assign qry_ok = (q_region == RG_DRAM) ? q_cap : (q_region != RG_NONE);

  p_qry_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode32 && $stable(mode32) && $stable(qry_addr[31:0]) |-> $stable(qry_ok));
endmodule

// File: tb/test_addr_router.sv
module test_addr_router;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;

  logic clk = 0, rst_n = 0, mode32 = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [1:0] req_size = 0;
  logic [AW-1:0] req_addr = 0, qry_addr = 0;
  logic [63:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err, mem_valid, mem_write, dev_valid, dev_write, qry_ok;
  logic [63:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [1:0] mem_size, dev_sel;
  logic [AW-1:0] mem_offset;
  logic [31:0] dev_addr;
  logic [7:0] dev_wdata, dev_rdata, rom_rdata;
  logic [11:0] rom_idx;
  logic mem_ready = 0, dev_ready = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_router #(.ADDR_W(AW), .MEM_BYTES(64'd256)) i_addr_router (.*);

  logic [7:0] dram [256];
  logic [7:0] devm [4][256];
  int errors = 0, checks = 0, cyc = 0;
  int n_mem, n_dev, last_msize, last_sel;
  logic [31:0] first_daddr, last_daddr;

  function automatic logic [7:0] rom_byte(input logic [11:0] i);
    return 8'((i * 13 + 5) & 12'hFF);
  endfunction
  assign rom_rdata = rom_byte(rom_idx);
  assign dev_rdata = devm[dev_sel][dev_addr[7:0]];
  always_comb
    for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] = dram[8'(mem_offset + AW'(k))];

  always @(negedge clk) begin
    cyc++;
    mem_ready <= (cyc % 3) != 1;
    dev_ready <= (cyc % 4) != 2;
  end

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      n_mem++; last_msize = mem_size;
      if (mem_write)
        for (int k = 0; k < (1 << mem_size); k++) dram[8'(mem_offset + AW'(k))] <= mem_wdata[8*k +: 8];
    end
    if (dev_valid && dev_ready) begin
      if (n_dev == 0) first_daddr = dev_addr;
      n_dev++; last_daddr = dev_addr; last_sel = dev_sel;
      if (dev_write) devm[dev_sel][dev_addr[7:0]] <= dev_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [1:0] sz, input logic [AW-1:0] a,
                        input logic [63:0] wd, output logic [63:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1; req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    n_mem = 0; n_dev = 0;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata; er = rsp_err;
    @(negedge clk);
  endtask

  function automatic logic [63:0] wmask(input logic [1:0] sz);
    return (sz == 3) ? '1 : ((64'd1 << (8 << sz)) - 1);
  endfunction

  function automatic bit qry_exp(input logic [AW-1:0] a, input bit m32);
    logic [AW-1:0] x = m32 ? {32'd0, a[31:0]} : a;
    if (x >= 64'h8000_0000) return (x - 64'h8000_0000) < 256;
    if (x[63:32] != 0) return 0;
    return (x >= 'h1020 && x <= 'h1FFF) || (x >= 'h0200_0000 && x <= 'h0200_FFFF) ||
           (x >= 'h0C00_0000 && x <= 'h0FFF_FFFF) || (x >= 'h1000_0000 && x <= 'h1000_00FF) ||
           (x >= 'h1000_1000 && x <= 'h1000_1FFF);
  endfunction

  initial begin
    int lim = 100000;
    while (cyc < lim) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, lim);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] rd, pat, exp;
    logic er;
    logic [AW-1:0] bases [4];
    logic [AW-1:0] qa [20];
    bases = '{64'h0200_0010, 64'h0C00_0020, 64'h1000_0008, 64'h1000_1030};
    for (int i = 0; i < 256; i++) begin
      dram[i] = 8'(i ^ 8'h5A);
      for (int s = 0; s < 4; s++) devm[s][i] = 8'(i + s);
    end
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_valid && !dev_valid, "R1 reset",
          {req_ready, rsp_valid, mem_valid, dev_valid}, 64'h8);
    rst_n = 1;

    // R2: fast path sweep over sizes and offsets
    foreach (bases[j]) begin end
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 4; o++) begin
        logic [AW-1:0] a = 64'h8000_0000 + AW'(o * 60 + sz);
        pat = 64'h0123_4567_89AB_CDEF ^ (64'(o) << 8) ^ 64'(sz);
        access(1, 2'(sz), a, pat, rd, er);
        check(rd == 0 && !er, "R9 write rdata", rd, 0);
        access(0, 2'(sz), a, 0, rd, er);
        exp = pat & wmask(2'(sz));
        check(rd == exp && !er, "R2 fast read", rd, exp);
        check(n_mem == 1 && last_msize == sz, "R2 single txn", n_mem, 1);
      end

    // R3/R4: device fan-out
    for (int s = 0; s < 4; s++)
      for (int sz = 0; sz < 4; sz++) begin
        pat = 64'hF0E1_D2C3_B4A5_9687 + 64'(s * 16 + sz);
        access(1, 2'(sz), bases[s], pat, rd, er);
        check(n_dev == (1 << sz) && !er, "R3 byte count", n_dev, 1 << sz);
        check(first_daddr == bases[s][31:0] && last_daddr == bases[s][31:0] + 32'((1 << sz) - 1),
              "R3 ascending", last_daddr, bases[s][31:0] + 32'((1 << sz) - 1));
        check(last_sel == s, "R4 dev_sel", last_sel, s);
        check(devm[s][bases[s][7:0]] == pat[7:0], "R3 little-endian lane0",
              devm[s][bases[s][7:0]], pat[7:0]);
        access(0, 2'(sz), bases[s], 0, rd, er);
        exp = pat & wmask(2'(sz));
        check(rd == exp, "R4 device readback", rd, exp);
      end

    // R5: ROM
    for (int a = 'h1020; a < 'h1FF8; a += 'h1F3) begin
      access(0, 2'd3, AW'(a), 0, rd, er);
      for (int k = 0; k < 8; k++) exp[8*k +: 8] = rom_byte(12'(a - 'h1020 + k));
      check(rd == exp && !er && n_mem == 0 && n_dev == 0, "R5 rom read", rd, exp);
    end
    access(0, 2'd0, 64'h1FFF, 0, rd, er);
    check(rd == {56'd0, rom_byte(12'hFDF)} && !er, "R5 rom last", rd, rom_byte(12'hFDF));
    access(1, 2'd2, 64'h1024, 64'hFFFF_FFFF, rd, er);
    check(er && n_mem == 0 && n_dev == 0, "R5 rom write error", er, 1);

    // R6: unmapped
    access(1, 2'd3, 64'h0000_3000, 64'h1111, rd, er);
    check(er && n_mem == 0 && n_dev == 0, "R6 unmapped write dropped", n_mem + n_dev, 0);
    access(0, 2'd1, 64'h101F, 0, rd, er);
    exp = {48'd0, rom_byte(12'd0), 8'd0};
    check(er && rd == exp, "R6 partial rom", rd, exp);
    access(1, 2'd1, 64'h8000_0000, 64'hBEEF, rd, er);
    access(0, 2'd2, 64'h7FFF_FFFE, 0, rd, er);
    check(er && rd == 64'hBEEF_0000 && n_mem == 2 && last_msize == 0, "R6 cross into dram", rd, 64'hBEEF_0000);

    // R3 wrap of 64-bit space
    access(0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFC, 0, rd, er);
    check(er && n_mem == 4 && last_msize == 0 && rd[63:32] == 0, "R3 wrap 64", n_mem, 4);

    // R7: 32-bit mode
    mode32 = 1;
    access(1, 2'd2, 64'hABCD_0001_8000_0010, 64'hCAFE_F00D, rd, er);
    access(0, 2'd2, 64'h0000_0000_8000_0010, 0, rd, er);
    check(rd == 64'hCAFE_F00D && !er && n_mem == 1, "R7 masked dram", rd, 64'hCAFE_F00D);
    access(0, 2'd2, 64'h5_FFFF_FFFE, 0, rd, er);
    check(er && n_mem == 2, "R7 32-bit wrap fans out", n_mem, 2);
    access(0, 2'd0, 64'h7_1000_0008, 0, rd, er);
    check(!er && n_dev == 1 && last_sel == 2, "R7 masked device", last_sel, 2);

    // R8: validity query sweep, both modes
    qa = '{64'h101F, 64'h1020, 64'h1FFF, 64'h2000, 64'h01FF_FFFF, 64'h0200_0000, 64'h0200_FFFF,
           64'h0201_0000, 64'h0BFF_FFFF, 64'h0FFF_FFFF, 64'h1000_00FF, 64'h1000_0100, 64'h1000_1000,
           64'h1000_1FFF, 64'h1000_2000, 64'h7FFF_FFFF, 64'h8000_00FF, 64'h8000_0100,
           64'h1_1000_0000, 64'h1_8000_0000};
    for (int m = 0; m < 2; m++) begin
      mode32 = m[0];
      foreach (qa[i]) begin
        @(negedge clk); qry_addr = qa[i];
        #1;
        check(qry_ok == qry_exp(qa[i], m[0]), "R8 query", qry_ok, qry_exp(qa[i], m[0]));
      end
    end
    mode32 = 0;

    // R1: response back-pressure
    rsp_ready = 0;
    @(negedge clk); req_valid = 1; req_write = 0; req_size = 2; req_addr = 64'h8000_0010;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    repeat (4) @(negedge clk);
    check(rsp_valid && rsp_rdata == rd && !req_ready, "R1 hold under back-pressure", rsp_rdata, rd);
    rsp_ready = 1;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R1 release", rsp_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule